// File: doc/BRIEF.md
# Rotational Position and Status Unit

This block tracks where a head-per-track rotating store is positioned and builds the 16-bit status word a host reads from the store's control channel. Position is not taken from an index mark. A free-running divider counts word-times, and every sector's worth of word-times advances a sector counter. That counter wraps at the sector count of the selected medium type: 32 sectors per track in drum mode and 90 in disk mode.

A transfer sequencer next to this block issues a start with a target sector and later a clear-control. It uses the coincidence pulse from this block to know that the heads have reached the requested sector. The sequencer also sets the sticky condition bits (sector flag, read inhibit, write enabled, parity error). This block holds those bits and merges them with ready, busy, coincidence, abort and the live sector number. A medium-present input decides whether the live fields appear in the word. The control channel has no flag storage, so a skip-on-flag-clear test always answers yes.

Top module: `rps_status_unit`

## Requirements
- R1: Synchronous active-low reset clears the word-time divider, the sector counter (`cur_sector` = 0), the stored condition bits and the coincidence pulse.
- R2: With `mode_drum` = 1 the sector number advances by one every 64 word-times and returns to 0 after sector 31.
- R3: With `mode_drum` = 0 the sector number advances by one every 64 word-times and returns to 0 after sector 89.
- R4: A change of `mode_drum` does not reset the count. If the current sector is at or above the new sector count, the next sector boundary goes to 0.
- R5: With a medium present, `status_word` holds: bit 15 sector flag, bits 14:8 current sector, bit 7 ready (1), bit 6 read inhibit, bit 5 coincidence, bit 4 zero, bit 3 abort, bit 2 write enabled, bit 1 parity error, bit 0 busy (= `xfer_pending`).
- R6: With no medium present, `status_word` shows only the stored bits (15, 6, 5, 3, 2, 1). Bits 14:7, 4 and 0 read 0.
- R7: While armed, `coin_pulse` is high for exactly one cycle each time the sector counter takes the target value. Coincidence bit 5 is set in that same cycle. A start or clear-control in the boundary cycle suppresses the pulse.
- R8: `start` arms the unit, captures `tgt_sector` and clears every stored bit. `clr_ctl` disarms the unit and clears bit 5. Start wins over all other updates in the same cycle.
- R9: A coincidence with no medium present sets the stored status to abort only (`status_word` = 16'h0008).
- R10: `skip` equals `flag_test` in every cycle, whatever the state.
- R11: The pulses `set_sec_flag`, `set_rd_inhibit`, `set_wr_enabled` and `set_parity` each set their bit (15, 6, 2, 1), and the bit holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_drum | input | 1 | 1 selects drum geometry (32 sectors), 0 selects disk geometry (90 sectors) |
| medium_present | input | 1 | A medium is mounted; enables ready, position and busy in the status |
| xfer_pending | input | 1 | Sequencer has a transfer outstanding; shown as busy |
| start | input | 1 | Start pulse; arms coincidence, captures target, clears stored bits |
| clr_ctl | input | 1 | Clear-control pulse; disarms coincidence, clears coincidence bit |
| tgt_sector | input | 7 | Requested sector, captured on start |
| set_sec_flag | input | 1 | Sets status bit 15 |
| set_rd_inhibit | input | 1 | Sets status bit 6 |
| set_wr_enabled | input | 1 | Sets status bit 2 |
| set_parity | input | 1 | Sets status bit 1 |
| flag_test | input | 1 | Host tests the control-channel flag for clear |
| cur_sector | output | 7 | Sector currently under the heads |
| coin_pulse | output | 1 | One-cycle pulse when the target sector is reached while armed |
| status_word | output | 16 | Assembled status word |
| skip | output | 1 | Answer to the flag-clear test |

## Verification
The hardest case to reach from the ports is the change of geometry while the counter sits above the drum limit. The counter must be at a sector of 32 or more in disk mode, and that takes thousands of cycles from reset. The stimulus runs a full disk revolution and then waits for sector 50. It switches to drum mode there and checks that the next boundary lands on 0. The abort path also needs a pending coincidence with the medium removed. The bench starts with no medium, sets a parity bit, and waits out a revolution to see that everything but abort has been cleared.

// File: rtl/rps_pkg.sv
// Package: shared constants and types for the rotational position unit.
// Assumes a 16-bit status word with a 7-bit sector field.
package rps_pkg;
    localparam int STAT_W   = 16;
    localparam int POS_W    = 7;
    localparam int B_SECFLG = 15;
    localparam int B_POS_LO = 8;
    localparam int B_READY  = 7;
    localparam int B_RINH   = 6;
    localparam int B_SAC    = 5;
    localparam int B_ABORT  = 3;
    localparam int B_WEN    = 2;
    localparam int B_PARITY = 1;
    localparam int B_BUSY   = 0;

    // Sticky condition bits held between a start and the next start.
    typedef struct packed {
        logic sec_flag;
        logic rd_inhibit;
        logic coincide;
        logic aborted;
        logic wr_enabled;
        logic parity_err;
    } stored_t;
endpackage

// File: rtl/rps_word_timer.sv
// Word-time divider: counts clocks into word-times and word-times into
// sectors. Emits sector_end on the clock whose edge finishes a sector.
// Assumes CLKS_PER_WORD >= 1 and WORDS_PER_SECTOR >= 2.
module rps_word_timer #(
    parameter int CLKS_PER_WORD    = 1,
    parameter int WORDS_PER_SECTOR = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic sector_end
);
    localparam int WW = $clog2(WORDS_PER_SECTOR);
    localparam logic [WW-1:0] LAST_WORD = WW'(WORDS_PER_SECTOR - 1);

    logic          word_tick;
    logic [WW-1:0] word_q;

    generate
        if (CLKS_PER_WORD == 1) begin : g_direct
            assign word_tick = 1'b1;
        end else begin : g_prescale
            localparam int PW = $clog2(CLKS_PER_WORD);
            localparam logic [PW-1:0] LAST_CLK = PW'(CLKS_PER_WORD - 1);
            logic [PW-1:0] pre_q;
            // Count clocks within one word-time.
            always_ff @(posedge clk) begin
                if (!rst_n)                pre_q <= '0;
                else if (pre_q == LAST_CLK) pre_q <= '0;
                else                       pre_q <= pre_q + 1'b1;
            end
            assign word_tick = (pre_q == LAST_CLK);
        end
    endgenerate

    // Count word-times within one sector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (word_tick) begin
            if (word_q == LAST_WORD) word_q <= '0;
            else                     word_q <= word_q + 1'b1;
        end
    end

    assign sector_end = word_tick && (word_q == LAST_WORD);
endmodule

// File: rtl/rps_sector_counter.sv
// Sector counter: advances on each sector end and wraps at the sector count
// of the selected geometry. A value left above a smaller limit after a mode
// change wraps to zero at the next boundary. Also offers the next value.
// Assumes both sector counts fit in POS_W bits.
module rps_sector_counter
    import rps_pkg::*;
#(
    parameter int DRUM_SECTORS = 32,
    parameter int DISK_SECTORS = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sector_end,
    input  logic             mode_drum,
    output logic [POS_W-1:0] cur_sector,
    output logic [POS_W-1:0] sec_next
);
    localparam logic [POS_W:0] DRUM_LIM = (POS_W + 1)'(DRUM_SECTORS);
    localparam logic [POS_W:0] DISK_LIM = (POS_W + 1)'(DISK_SECTORS);

    logic [POS_W-1:0] sec_q;
    logic [POS_W:0]   inc;
    logic [POS_W:0]   limit;

    // Work out the value the counter takes at the next boundary.
    always_comb begin
        limit    = mode_drum ? DRUM_LIM : DISK_LIM;
        inc      = {1'b0, sec_q} + 1'b1;
        sec_next = (inc >= limit) ? '0 : inc[POS_W-1:0];
    end

    // Hold the sector under the heads.
    always_ff @(posedge clk) begin
        if (!rst_n)          sec_q <= '0;
        else if (sector_end) sec_q <= sec_next;
    end

    assign cur_sector = sec_q;
endmodule

// File: rtl/rps_status_reg.sv
// Stored status and coincidence: keeps the arm state and target, detects
// arrival at the target at each sector boundary, and holds the sticky
// condition bits. Start has priority, then abort, then sets and clears.
// Assumes start and clr_ctl are single-cycle pulses from the sequencer.
module rps_status_reg
    import rps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clr_ctl,
    input  logic [POS_W-1:0] tgt_sector,
    input  logic             sector_end,
    input  logic [POS_W-1:0] sec_next,
    input  logic             medium_present,
    input  logic             set_sec_flag,
    input  logic             set_rd_inhibit,
    input  logic             set_wr_enabled,
    input  logic             set_parity,
    output stored_t          stored,
    output logic             coin_pulse
);
    logic             armed_q;
    logic [POS_W-1:0] tgt_q;
    logic             hit;
    logic             coin_q;
    stored_t          st_q;

    // Arrival at the target on this boundary, unless a command overrides it.
    assign hit = sector_end && armed_q && !start && !clr_ctl && (sec_next == tgt_q);

    // Arm on start, disarm on clear-control, capture the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            tgt_q   <= '0;
        end else if (start) begin
            armed_q <= 1'b1;
            tgt_q   <= tgt_sector;
        end else if (clr_ctl) begin
            armed_q <= 1'b0;
        end
    end

    // Register the coincidence so it lines up with the new sector value.
    always_ff @(posedge clk) begin
        if (!rst_n) coin_q <= 1'b0;
        else        coin_q <= hit;
    end

    // Update the sticky condition bits.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            st_q <= '0;
        end else if (hit && !medium_present) begin
            st_q         <= '0;
            st_q.aborted <= 1'b1;
        end else begin
            if (set_sec_flag)   st_q.sec_flag   <= 1'b1;
            if (set_rd_inhibit) st_q.rd_inhibit <= 1'b1;
            if (set_wr_enabled) st_q.wr_enabled <= 1'b1;
            if (set_parity)     st_q.parity_err <= 1'b1;
            if (clr_ctl)        st_q.coincide   <= 1'b0;
            else if (hit)       st_q.coincide   <= 1'b1;
        end
    end

    assign stored     = st_q;
    assign coin_pulse = coin_q;
endmodule

// File: rtl/rps_status_unit.sv
// Top: rotational position and status unit. Derives the sector under the
// heads from elapsed word-times, signals coincidence with a requested
// sector, and assembles the host status word, gated by medium presence.
// Assumes a single clock domain shared with the transfer sequencer.
module rps_status_unit
    import rps_pkg::*;
#(
    parameter int CLKS_PER_WORD    = 1,
    parameter int WORDS_PER_SECTOR = 64,
    parameter int DRUM_SECTORS     = 32,
    parameter int DISK_SECTORS     = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_drum,
    input  logic              medium_present,
    input  logic              xfer_pending,
    input  logic              start,
    input  logic              clr_ctl,
    input  logic [6:0]        tgt_sector,
    input  logic              set_sec_flag,
    input  logic              set_rd_inhibit,
    input  logic              set_wr_enabled,
    input  logic              set_parity,
    input  logic              flag_test,
    output logic [6:0]        cur_sector,
    output logic              coin_pulse,
    output logic [15:0]       status_word,
    output logic              skip
);
    logic             sector_end;
    logic [POS_W-1:0] sec_next;
    logic [POS_W-1:0] sec_cur;
    stored_t          stored;

    rps_word_timer #(
        .CLKS_PER_WORD   (CLKS_PER_WORD),
        .WORDS_PER_SECTOR(WORDS_PER_SECTOR)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sector_end(sector_end)
    );

    rps_sector_counter #(
        .DRUM_SECTORS(DRUM_SECTORS),
        .DISK_SECTORS(DISK_SECTORS)
    ) u_sector (
        .clk       (clk),
        .rst_n     (rst_n),
        .sector_end(sector_end),
        .mode_drum (mode_drum),
        .cur_sector(sec_cur),
        .sec_next  (sec_next)
    );

    rps_status_reg u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .clr_ctl       (clr_ctl),
        .tgt_sector    (tgt_sector),
        .sector_end    (sector_end),
        .sec_next      (sec_next),
        .medium_present(medium_present),
        .set_sec_flag  (set_sec_flag),
        .set_rd_inhibit(set_rd_inhibit),
        .set_wr_enabled(set_wr_enabled),
        .set_parity    (set_parity),
        .stored        (stored),
        .coin_pulse    (coin_pulse)
    );

    // Merge stored bits with the live fields when a medium is mounted.
    always_comb begin
        status_word           = '0;
        status_word[B_SECFLG] = stored.sec_flag;
        status_word[B_RINH]   = stored.rd_inhibit;
        status_word[B_SAC]    = stored.coincide;
        status_word[B_ABORT]  = stored.aborted;
        status_word[B_WEN]    = stored.wr_enabled;
        status_word[B_PARITY] = stored.parity_err;
        if (medium_present) begin
            status_word[B_POS_LO +: POS_W] = sec_cur;
            status_word[B_READY]           = 1'b1;
            status_word[B_BUSY]            = xfer_pending;
        end
    end

    // The control channel has no flag storage: a clear-flag test always skips.
    assign skip       = flag_test;
    assign cur_sector = sec_cur;
endmodule

// File: rtl/rps_status_unit_chk.sv
// Checker: temporal properties of the rotational position unit, bound to
// the top module. Assumes the default geometry of at least two sectors.
module rps_status_unit_chk
    import rps_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        medium_present,
    input logic        start,
    input logic        clr_ctl,
    input logic [6:0]  cur_sector,
    input logic        coin_pulse,
    input logic [15:0] status_word
);
    // R1: a reset edge leaves the counter at home and no pulse.
    a_r1_reset_home: assert property (@(posedge clk)
        !rst_n |=> (cur_sector == 7'd0 && !coin_pulse));

    // R2: the sector number only steps by one or wraps to zero.
    a_r2_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sector != $past(cur_sector)) |->
        (cur_sector == $past(cur_sector) + 7'd1 || cur_sector == 7'd0));

    // R7: coincidence lasts one cycle.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        coin_pulse |=> !coin_pulse);

    // R7: coincidence only comes with a fresh sector value.
    a_r7_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        coin_pulse |-> (cur_sector != $past(cur_sector)));

    // R8: clear-control leaves the coincidence bit clear.
    a_r8_clr_sac: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ctl |=> !status_word[B_SAC]);

    // R8: start clears every stored bit.
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((status_word & 16'h806E) == 16'h0000));

    // R9: coincidence without a medium leaves abort alone.
    a_r9_abort_only: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_pulse && !medium_present && !$past(medium_present)) |->
        (status_word == 16'h0008));
endmodule

bind rps_status_unit rps_status_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .medium_present(medium_present),
    .start         (start),
    .clr_ctl       (clr_ctl),
    .cur_sector    (cur_sector),
    .coin_pulse    (coin_pulse),
    .status_word   (status_word)
);

// File: tb/rps_status_unit_test.sv
// Scoreboard bench: the driver pushes expected status words into a queue
// at the falling edge; a monitor pops them 5 ns after the next rising edge.
// A position model runs alongside and is compared every cycle.
module rps_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_drum = 1'b0;
    logic        medium_present = 1'b0;
    logic        xfer_pending = 1'b0;
    logic        start = 1'b0;
    logic        clr_ctl = 1'b0;
    logic [6:0]  tgt_sector = 7'd0;
    logic        set_sec_flag = 1'b0;
    logic        set_rd_inhibit = 1'b0;
    logic        set_wr_enabled = 1'b0;
    logic        set_parity = 1'b0;
    logic        flag_test = 1'b0;
    logic [6:0]  cur_sector;
    logic        coin_pulse;
    logic [15:0] status_word;
    logic        skip;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rps_status_unit uut (
        .clk(clk), .rst_n(rst_n), .mode_drum(mode_drum),
        .medium_present(medium_present), .xfer_pending(xfer_pending),
        .start(start), .clr_ctl(clr_ctl), .tgt_sector(tgt_sector),
        .set_sec_flag(set_sec_flag), .set_rd_inhibit(set_rd_inhibit),
        .set_wr_enabled(set_wr_enabled), .set_parity(set_parity),
        .flag_test(flag_test), .cur_sector(cur_sector),
        .coin_pulse(coin_pulse), .status_word(status_word), .skip(skip)
    );

    typedef struct {
        logic [15:0] val;
        bit          with_pos;
        string       tag;
    } exp_t;
    exp_t q[$];

    // Position model from the requirements: 64 word-times per sector.
    int m_w = 0, m_s = 0, m_tgt = 0;
    bit m_armed = 0, m_coin = 0;
    always @(posedge clk) begin
        int lim, nx;
        if (!rst_n) begin
            m_w = 0; m_s = 0; m_armed = 0; m_tgt = 0; m_coin = 0;
        end else begin
            lim = mode_drum ? 32 : 90;
            nx  = (m_s + 1 >= lim) ? 0 : m_s + 1;
            m_coin = (m_w == 63) && m_armed && !start && !clr_ctl && (nx == m_tgt);
            if (start) begin m_armed = 1; m_tgt = tgt_sector; end
            else if (clr_ctl) m_armed = 0;
            if (m_w == 63) begin m_s = nx; m_w = 0; end
            else m_w = m_w + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: continuous model compare plus scoreboard pops.
    always @(posedge clk) begin
        exp_t it;
        logic [15:0] e;
        #5;
        if (!done) begin
            chk(cur_sector == 7'(m_s), mode_drum ? "R2 sector position" : "R3 sector position",
                cur_sector, m_s);
            chk(coin_pulse == m_coin, "R7 coincidence pulse", coin_pulse, m_coin);
            if (q.size() > 0) begin
                it = q.pop_front();
                e  = it.val | (it.with_pos ? (16'(m_s) << 8) : 16'h0);
                chk(status_word == e, it.tag, status_word, e);
            end
        end
    end

    task automatic push(input logic [15:0] v, input bit wp, input string tag);
        exp_t it;
        it.val = v; it.with_pos = wp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_coin(input string tag, input int exp_sec);
        bit seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(posedge clk); #5;
            if (coin_pulse) seen = 1;
        end
        chk(seen, tag, seen, 1);
        chk(cur_sector == 7'(exp_sec), tag, cur_sector, exp_sec);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(3);
        push(16'h0000, 0, "R1 reset status");
        cycles(1);
        chk(cur_sector == 0 && !coin_pulse, "R1 reset position", cur_sector, 0);
        rst_n = 1'b1;
        // R10: skip answers in both medium states.
        flag_test = 1'b1; #1;
        chk(skip == 1'b1, "R10 skip no medium", skip, 1);
        @(negedge clk);
        medium_present = 1'b1; #1;
        chk(skip == 1'b1, "R10 skip with medium", skip, 1);
        push(16'h0080, 1, "R5 ready with position");
        @(negedge clk); flag_test = 1'b0; #1;
        chk(skip == 1'b0, "R10 skip follows test", skip, 0);
        // R3: full disk revolution, then change geometry above drum limit.
        cycles(90 * 64 + 100);
        while (cur_sector != 7'd50) @(negedge clk);
        mode_drum = 1'b1;
        while (cur_sector == 7'd50) @(negedge clk);
        chk(cur_sector == 0, "R4 wrap after mode change", cur_sector, 0);
        cycles(32 * 64 + 100);
        // R5 and R6: busy visible only with a medium.
        xfer_pending = 1'b1;
        push(16'h0081, 1, "R5 busy shown");
        @(negedge clk); medium_present = 1'b0;
        push(16'h0000, 0, "R6 busy hidden");
        @(negedge clk); xfer_pending = 1'b0;
        // R11: sticky condition bits, no medium.
        set_parity = 1'b1; push(16'h0002, 0, "R11 parity set");
        @(negedge clk); set_parity = 1'b0; set_wr_enabled = 1'b1;
        push(16'h0006, 0, "R11 write enabled set");
        @(negedge clk); set_wr_enabled = 1'b0; set_rd_inhibit = 1'b1;
        push(16'h0046, 0, "R11 read inhibit set");
        @(negedge clk); set_rd_inhibit = 1'b0; set_sec_flag = 1'b1;
        push(16'h8046, 0, "R6 stored bits only");
        @(negedge clk); set_sec_flag = 1'b0; medium_present = 1'b1;
        push(16'h80C6, 1, "R5 full layout");
        cycles(3);
        push(16'h80C6, 1, "R11 bits held");
        // R8: start clears, arms target 5.
        @(negedge clk); start = 1'b1; tgt_sector = 7'd5;
        push(16'h0080, 1, "R8 start clears");
        @(negedge clk); start = 1'b0;
        wait_coin("R7 target reached", 5);
        push(16'h00A0, 1, "R7 coincidence bit");
        @(negedge clk); clr_ctl = 1'b1;
        push(16'h0080, 1, "R8 clear-control clears");
        @(negedge clk); clr_ctl = 1'b0;
        cycles(32 * 64 + 80);
        push(16'h0080, 1, "R8 disarmed");
        // R8: a fresh start clears a set coincidence bit.
        @(negedge clk); start = 1'b1; tgt_sector = 7'd7;
        @(negedge clk); start = 1'b0;
        wait_coin("R7 second target", 7);
        start = 1'b1; tgt_sector = 7'd7;
        push(16'h0080, 1, "R8 restart clears coincidence");
        @(negedge clk); start = 1'b0;
        // R9: coincidence with no medium gives abort only.
        medium_present = 1'b0;
        @(negedge clk); start = 1'b1; tgt_sector = 7'd3;
        @(negedge clk); start = 1'b0; set_parity = 1'b1;
        push(16'h0002, 0, "R9 parity before arrival");
        @(negedge clk); set_parity = 1'b0;
        wait_coin("R9 arrival without medium", 3);
        push(16'h0008, 0, "R9 abort only");
        @(negedge clk); medium_present = 1'b1;
        push(16'h0088, 1, "R5 abort with medium");
        cycles(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule